// File: doc/BRIEF.md
# Vertical Timing and Field Status Generator

This block derives the vertical timing of a 525-line, 60 Hz interlaced stream from two strobes. The line strobe arrives once per video line, and the frame strobe arrives at the start of the first field. An internal counter follows the standard line numbering. The block decodes the count into six status signals:

- an active-picture window (`vref_o`)
- a programmable field identifier (`fid_o`)
- a vertical sync pulse (`vs_o`)
- a field-phase pulse (`v123_o`)
- an odd-field flag (`odd_o`)
- a registered copy of the horizontal reference (`href_o`)

Two status pins can each carry any one of these signals. Each pin has its own 4-bit select code, so the two pins can show different signals at the same time.

The odd-field flag is taken at the falling edge of the field-phase pulse. At that edge the flag copies the level of the incoming horizontal reference.

The block also drives two controls for downstream filters, both based on the active-picture window:

- Outside the window, a filter bypass is raised if the blanking-bypass control is set.
- Outside the window, the chroma delay-line enable is always dropped.

All configuration arrives as plain input levels.

Top module: `vtiming_gen`

## Requirements
- R1: The line counter loads 1 on a frame strobe, and the frame strobe wins over a simultaneous line strobe. A line strobe alone adds one to the count, and a line strobe at line 525 returns the count to 1.
- R2: `vref_o` is high on lines 22–261 and 285–524 when `cfg_win_long`=0. It is high on lines 20–261 and 283–524 when `cfg_win_long`=1. It is low on every other line.
- R3: `fid_o` equals (line >= `cfg_fid_line`) XOR `cfg_fid_pol`.
- R4: `vs_o` is high on lines 4–6 and 266–268 and low on every other line.
- R5: `v123_o` is high on lines 1–3 and 263–265 and low on every other line.
- R6: `odd_o` takes the level of `href_i` in the cycle where `v123_o` falls, and holds its value at all other times.
- R7: Each status pin shows the signal named by its own select code. The codes are 0x7 for `href`, 0xA for `odd`, 0xB for `vs`, 0xC for `v123`, 0xE for `vref` and 0xF for `fid`. Any other code drives the pin low.
- R8: `filt_bypass_o` is high exactly when `vref_o` is low and `cfg_blank_bypass` is 1.
- R9: `chroma_en_o` follows `vref_o`, so it is low whenever the window is low.
- R10: All outputs are registered and change one clock after the line counter changes. `href_o` is `href_i` delayed by one clock.
- R11: While `rst_n` is low, every output is low and the counter returns to line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb_i | input | 1 | One-cycle strobe per video line |
| frame_stb_i | input | 1 | One-cycle strobe at the start of field 1 |
| href_i | input | 1 | Horizontal reference level |
| cfg_win_long | input | 1 | Selects the long active-picture window |
| cfg_fid_line | input | 9 | Line on which the field identifier switches |
| cfg_fid_pol | input | 1 | Inverts the field identifier |
| cfg_blank_bypass | input | 1 | Enables the filter bypass outside the window |
| cfg_sel_a | input | 4 | Signal select code for status pin A |
| cfg_sel_b | input | 4 | Signal select code for status pin B |
| stat_a_o | output | 1 | Status pin A |
| stat_b_o | output | 1 | Status pin B |
| vref_o | output | 1 | Active-picture window |
| fid_o | output | 1 | Field identifier |
| vs_o | output | 1 | Vertical sync pulse |
| v123_o | output | 1 | Field-phase pulse |
| odd_o | output | 1 | Odd-field flag |
| href_o | output | 1 | Registered horizontal reference |
| filt_bypass_o | output | 1 | Filter bypass during blanking |
| chroma_en_o | output | 1 | Chroma delay-line enable |

## Verification
The assertions check the following on every cycle:
- the counter stays in its range, reloads on a frame strobe and wraps after line 525;
- the chroma enable matches the window;
- the bypass is never high inside the window;
- sync never overlaps the window;
- the odd flag changes only where the field-phase pulse falls;
- a pin with an unlisted select code stays low.

The bench scenarios are needed for the rest:
- the exact line numbers of each window, pulse and field switch;
- the effect of the long-window, polarity and bypass settings;
- the routing of each valid select code to each pin;
- the level that the odd flag captures from the horizontal reference.

// File: rtl/vt_pkg.sv
// Shared types and select-code decoding for the vertical timing generator.
// Assumes select codes are 4 bits wide; unlisted codes yield a low pin.
package vt_pkg;

    localparam logic [3:0] SEL_HREF = 4'h7;
    localparam logic [3:0] SEL_ODD  = 4'hA;
    localparam logic [3:0] SEL_VS   = 4'hB;
    localparam logic [3:0] SEL_V123 = 4'hC;
    localparam logic [3:0] SEL_VREF = 4'hE;
    localparam logic [3:0] SEL_FID  = 4'hF;

    typedef struct packed {
        logic href;
        logic odd;
        logic vs;
        logic v123;
        logic vref;
        logic fid;
    } vt_status_t;

    // Report whether a select code names one of the routable signals.
    function automatic logic vt_sel_known(input logic [3:0] sel);
        return (sel == SEL_HREF) || (sel == SEL_ODD) || (sel == SEL_VS) ||
               (sel == SEL_V123) || (sel == SEL_VREF) || (sel == SEL_FID);
    endfunction

    // Return the status signal named by a select code, low when unlisted.
    function automatic logic vt_pick(input logic [3:0] sel, input vt_status_t s);
        case (sel)
            SEL_HREF: return s.href;
            SEL_ODD:  return s.odd;
            SEL_VS:   return s.vs;
            SEL_V123: return s.v123;
            SEL_VREF: return s.vref;
            SEL_FID:  return s.fid;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vt_line_counter.sv
// Line counter for an interlaced frame.
// The frame strobe loads line 1 and wins over a coincident line strobe.
// A line strobe advances the count and wraps from FRAME_LINES back to 1.
// Assumes both strobes are single-cycle pulses synchronous to clk.
module vt_line_counter #(
    parameter int FRAME_LINES = 525,
    localparam int LINE_W = $clog2(FRAME_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb_i,
    input  logic              frame_stb_i,
    output logic [LINE_W-1:0] line_o
);

    logic [LINE_W-1:0] line_q;

    // Track the current line number from the incoming strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= LINE_W'(1);
        end else if (frame_stb_i) begin
            line_q <= LINE_W'(1);
        end else if (line_stb_i) begin
            line_q <= (line_q == LINE_W'(FRAME_LINES)) ? LINE_W'(1) : line_q + 1'b1;
        end
    end

    assign line_o = line_q;

    // R1
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q >= LINE_W'(1)) && (line_q <= LINE_W'(FRAME_LINES)));
    // R1
    frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb_i |=> (line_q == LINE_W'(1)));
    // R1
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb_i && !frame_stb_i && line_q == LINE_W'(FRAME_LINES)) |=> (line_q == LINE_W'(1)));

endmodule

// File: rtl/vt_vdecode.sv
// Combinational decode of the line number into the window, sync, phase pulse and field id.
// Field 2 features sit FIELD_OFS lines after their field 1 counterparts.
// The long window opens LONG_LEAD lines earlier than the short window and closes on the same line.
module vt_vdecode #(
    parameter int FRAME_LINES = 525,
    parameter int FIELD_OFS   = 262,
    parameter int ACT_FIRST   = 22,
    parameter int ACT_LAST    = 261,
    parameter int ACT2_FIRST  = 285,
    parameter int ACT2_LAST   = 524,
    parameter int LONG_LEAD   = 2,
    parameter int VS_FIRST    = 4,
    parameter int PH_FIRST    = 1,
    parameter int PULSE_LEN   = 3,
    localparam int LINE_W = $clog2(FRAME_LINES + 1)
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic              win_long_i,
    input  logic [8:0]        fid_line_i,
    input  logic              fid_pol_i,
    output logic              vref_o,
    output logic              vs_o,
    output logic              v123_o,
    output logic              fid_o
);

    localparam int VS_LAST = VS_FIRST + PULSE_LEN - 1;
    localparam int PH_LAST = PH_FIRST + PULSE_LEN - 1;

    int ln;
    int lead;

    // Decode the per-line status levels from the current count.
    always_comb begin
        ln     = int'(line_i);
        lead   = win_long_i ? LONG_LEAD : 0;
        vref_o = ((ln >= ACT_FIRST - lead) && (ln <= ACT_LAST)) ||
                 ((ln >= ACT2_FIRST - lead) && (ln <= ACT2_LAST));
        vs_o   = ((ln >= VS_FIRST) && (ln <= VS_LAST)) ||
                 ((ln >= VS_FIRST + FIELD_OFS) && (ln <= VS_LAST + FIELD_OFS));
        v123_o = ((ln >= PH_FIRST) && (ln <= PH_LAST)) ||
                 ((ln >= PH_FIRST + FIELD_OFS) && (ln <= PH_LAST + FIELD_OFS));
        fid_o  = (ln >= int'(fid_line_i)) ^ fid_pol_i;
    end

endmodule

// File: rtl/vt_stat_pin.sv
// One registered status pin driven by a 4-bit select code over the shared menu.
// Assumes the status bundle holds next-cycle values, so the pin lines up with the other outputs.
module vt_stat_pin
    import vt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sel_i,
    input  vt_status_t status_i,
    output logic       stat_o
);

    logic stat_q;

    // Register the selected status signal onto the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= vt_pick(sel_i, status_i);
    end

    assign stat_o = stat_q;

    // R7
    unlisted_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vt_sel_known(sel_i) |=> !stat_o);

endmodule

// File: rtl/vtiming_gen.sv
// Vertical timing and field status generator.
// It counts lines, decodes the vertical status signals, registers them, latches the odd-field flag
// on the falling edge of the phase pulse, and routes the signals to two selectable status pins.
// Assumes strobes and href_i are synchronous to clk; all outputs reset low.
module vtiming_gen
    import vt_pkg::*;
#(
    parameter int FRAME_LINES = 525,
    parameter int NUM_PINS    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_stb_i,
    input  logic       frame_stb_i,
    input  logic       href_i,
    input  logic       cfg_win_long,
    input  logic [8:0] cfg_fid_line,
    input  logic       cfg_fid_pol,
    input  logic       cfg_blank_bypass,
    input  logic [3:0] cfg_sel_a,
    input  logic [3:0] cfg_sel_b,
    output logic       stat_a_o,
    output logic       stat_b_o,
    output logic       vref_o,
    output logic       fid_o,
    output logic       vs_o,
    output logic       v123_o,
    output logic       odd_o,
    output logic       href_o,
    output logic       filt_bypass_o,
    output logic       chroma_en_o
);

    localparam int LINE_W = $clog2(FRAME_LINES + 1);

    logic [LINE_W-1:0] line_w;
    logic vref_d, vs_d, v123_d, fid_d, odd_d;
    logic vref_q, vs_q, v123_q, fid_q, odd_q, href_q, byp_q, cen_q;
    vt_status_t nxt;
    logic [3:0] sel_w [NUM_PINS];
    logic [NUM_PINS-1:0] stat_w;

    vt_line_counter #(.FRAME_LINES(FRAME_LINES)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_stb_i (line_stb_i),
        .frame_stb_i(frame_stb_i),
        .line_o     (line_w)
    );

    vt_vdecode #(.FRAME_LINES(FRAME_LINES)) u_dec (
        .line_i    (line_w),
        .win_long_i(cfg_win_long),
        .fid_line_i(cfg_fid_line),
        .fid_pol_i (cfg_fid_pol),
        .vref_o    (vref_d),
        .vs_o      (vs_d),
        .v123_o    (v123_d),
        .fid_o     (fid_d)
    );

    // Capture href at the falling edge of the phase pulse, else hold.
    assign odd_d = (v123_q && !v123_d) ? href_i : odd_q;

    // Bundle the next-cycle status values for the pin selectors.
    assign nxt = '{href: href_i, odd: odd_d, vs: vs_d, v123: v123_d, vref: vref_d, fid: fid_d};

    // Register the dedicated status and filter-control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {vref_q, vs_q, v123_q, fid_q, odd_q, href_q, byp_q, cen_q} <= '0;
        end else begin
            vref_q <= vref_d;
            vs_q   <= vs_d;
            v123_q <= v123_d;
            fid_q  <= fid_d;
            odd_q  <= odd_d;
            href_q <= href_i;
            byp_q  <= !vref_d && cfg_blank_bypass;
            cen_q  <= vref_d;
        end
    end

    assign sel_w[0] = cfg_sel_a;
    assign sel_w[1] = cfg_sel_b;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        vt_stat_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (sel_w[p]),
            .status_i(nxt),
            .stat_o  (stat_w[p])
        );
    end

    assign stat_a_o      = stat_w[0];
    assign stat_b_o      = stat_w[1];
    assign vref_o        = vref_q;
    assign fid_o         = fid_q;
    assign vs_o          = vs_q;
    assign v123_o        = v123_q;
    assign odd_o         = odd_q;
    assign href_o        = href_q;
    assign filt_bypass_o = byp_q;
    assign chroma_en_o   = cen_q;

    // R9
    chroma_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_en_o == vref_o);
    // R8
    bypass_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filt_bypass_o |-> !vref_o);
    // R6
    odd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_o != $past(odd_o)) |-> ($past(v123_o) && !v123_o));
    // R4
    sync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_o |-> !vref_o);

endmodule

// File: tb/test_vtiming_gen.sv
`timescale 1ns/1ps
module test_vtiming_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_stb = 1'b0, frame_stb = 1'b0, href = 1'b0;
    logic cfg_win_long = 1'b0, cfg_fid_pol = 1'b0, cfg_blank_bypass = 1'b0;
    logic [8:0] cfg_fid_line = 9'd263;
    logic [3:0] cfg_sel_a = 4'h0, cfg_sel_b = 4'h0;
    logic stat_a, stat_b, vref, fid, vs, v123, odd, href_out, byp, cen;

    int n_chk = 0, n_fail = 0;
    int cur = 1;
    logic e_odd = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vtiming_gen i_vtiming_gen (
        .clk(clk), .rst_n(rst_n), .line_stb_i(line_stb), .frame_stb_i(frame_stb),
        .href_i(href), .cfg_win_long(cfg_win_long), .cfg_fid_line(cfg_fid_line),
        .cfg_fid_pol(cfg_fid_pol), .cfg_blank_bypass(cfg_blank_bypass),
        .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b),
        .stat_a_o(stat_a), .stat_b_o(stat_b), .vref_o(vref), .fid_o(fid), .vs_o(vs),
        .v123_o(v123), .odd_o(odd), .href_o(href_out), .filt_bypass_o(byp), .chroma_en_o(cen)
    );

    function automatic logic m_vref(int l, logic lng);
        int ld = lng ? 2 : 0;
        return (l >= 22 - ld && l <= 261) || (l >= 285 - ld && l <= 524);
    endfunction
    function automatic logic m_vs(int l);
        return (l >= 4 && l <= 6) || (l >= 266 && l <= 268);
    endfunction
    function automatic logic m_v123(int l);
        return (l >= 1 && l <= 3) || (l >= 263 && l <= 265);
    endfunction
    function automatic logic m_fid(int l);
        return (l >= int'(cfg_fid_line)) ^ cfg_fid_pol;
    endfunction
    function automatic logic m_pick(logic [3:0] s, int l, logic h, logic o);
        case (s)
            4'h7: return h;
            4'hA: return o;
            4'hB: return m_vs(l);
            4'hC: return m_v123(l);
            4'hE: return m_vref(l, cfg_win_long);
            4'hF: return m_fid(l);
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s line %0d: actual %b expected %b", tag, cur, act, exp);
        end
    endtask

    task automatic check_all(logic h);
        chk("R2 vref", vref, m_vref(cur, cfg_win_long));
        chk("R3 fid", fid, m_fid(cur));
        chk("R4 vs", vs, m_vs(cur));
        chk("R5 v123", v123, m_v123(cur));
        chk("R6 odd", odd, e_odd);
        chk("R10 href", href_out, h);
        chk("R8 bypass", byp, !m_vref(cur, cfg_win_long) && cfg_blank_bypass);
        chk("R9 chroma", cen, m_vref(cur, cfg_win_long));
        chk("R7 pin A", stat_a, m_pick(cfg_sel_a, cur, h, e_odd));
        chk("R7 pin B", stat_b, m_pick(cfg_sel_b, cur, h, e_odd));
    endtask

    // One strobe, then sample after counter and output registers settle (R10).
    task automatic advance(bit use_fr, bit use_ln, bit inv_h);
        int nxt;
        logic h;
        nxt = use_fr ? 1 : (use_ln ? ((cur == 525) ? 1 : cur + 1) : cur);
        h = (nxt < 263) ^ inv_h;
        @(negedge clk);
        frame_stb = use_fr; line_stb = use_ln; href = h;
        @(negedge clk);
        frame_stb = 1'b0; line_stb = 1'b0;
        @(negedge clk);
        if (m_v123(cur) && !m_v123(nxt)) e_odd = h;
        cur = nxt;
        check_all(h);
        if (use_fr || nxt == 1) chk("R1 reload", v123, 1'b1);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cfg_win_long = 1'b0; cfg_fid_line = 9'd263; cfg_fid_pol = 1'b0;
        cfg_blank_bypass = 1'b1; cfg_sel_a = 4'hE; cfg_sel_b = 4'hF;
        repeat (4) @(negedge clk);
        // R11: everything low in reset
        chk("R11 vref", vref, 1'b0); chk("R11 fid", fid, 1'b0); chk("R11 vs", vs, 1'b0);
        chk("R11 v123", v123, 1'b0); chk("R11 odd", odd, 1'b0); chk("R11 byp", byp, 1'b0);
        chk("R11 cen", cen, 1'b0); chk("R11 pinA", stat_a, 1'b0); chk("R11 pinB", stat_b, 1'b0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        // R11: counter restarted at line 1
        chk("R11 line1", v123, 1'b1);

        // Frame A: short window, default field switch
        advance(1, 0, 0);
        for (int i = 0; i < 524; i++) advance(0, 1, 0);

        // Frame B: long window, moved and inverted field id, no bypass
        cfg_win_long = 1'b1; cfg_fid_line = 9'd100; cfg_fid_pol = 1'b1;
        cfg_blank_bypass = 1'b0; cfg_sel_a = 4'hC; cfg_sel_b = 4'hB;
        advance(1, 0, 1);
        for (int i = 0; i < 524; i++) advance(0, 1, 1);

        // Frame C: wrap without a frame strobe, odd/href routing then unlisted codes
        cfg_win_long = 1'b0; cfg_fid_line = 9'd263; cfg_fid_pol = 1'b0;
        cfg_blank_bypass = 1'b1; cfg_sel_a = 4'hA; cfg_sel_b = 4'h7;
        for (int i = 0; i < 525; i++) begin
            if (i == 300) begin cfg_sel_a = 4'h3; cfg_sel_b = 4'h0; end
            advance(0, 1, 0);
        end

        // R1: frame strobe wins over a coincident line strobe mid-frame
        cfg_sel_a = 4'hC; cfg_sel_b = 4'hA;
        for (int i = 0; i < 40; i++) advance(0, 1, 0);
        advance(1, 1, 0);
        for (int i = 0; i < 8; i++) advance(0, 1, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule